// File: doc/BRIEF.md
# SPI Command Sequencer with Chip-Select Timing

This block is an SPI master engine driven by a stream of command words. Every command is either a chip-select operation, which raises or drops one select line and then waits out a programmed guard time, or a byte operation, which runs eight serial clock periods and may transmit a byte, capture a byte, or both at once. Captured bytes leave the block as response entries through a valid/ready handshake.

The serial clock rate and the three guard times (after select assertion, before select release, after select release) come from counters whose width is a parameter, 12 bits by default. The clock idle level and the sampling edge follow the usual polarity and phase settings, so all four SPI modes are available. A per-line polarity mask decides whether each select line is active high or active low. Commands are taken one at a time, only while the engine is idle, so a command FIFO in front of it can be drained with a plain ready signal.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: While reset is held and right after it, `cmd_ready` is 1, `rsp_valid` is 0, `spi_sclk` equals `cfg_cpol` and every select line is at its inactive level.
- R2: A byte command with `cmd_wr`=1 transmits `cmd_data` most significant bit first; the value on `spi_mosi` at each sampling edge is the next bit of the byte.
- R3: A byte command with `cmd_rd`=1 captures eight `spi_miso` bits, first bit into bit 7, and presents them on `rsp_data` with `rsp_valid`=1; with `cmd_wr`=0 `spi_mosi` stays 0 for the whole byte.
- R4: With both `cmd_wr` and `cmd_rd` set, one byte is sent and one byte is received during the same eight clock periods.
- R5: Each `spi_sclk` half-period lasts `cfg_div`+1 clock cycles, and one byte produces exactly 16 `spi_sclk` transitions.
- R6: Between transfers `spi_sclk` rests at `cfg_cpol`; with `cfg_cpha`=0 data is sampled on the first edge of each clock period, with `cfg_cpha`=1 on the second.
- R7: A command with `cmd_cs`=1 performs no transfer; `cmd_data[7]`=1 asserts and 0 releases the line whose index is `cmd_data[6:0]`; an index at or above the line count changes no line but still runs the guard time.
- R8: After a select assertion is accepted, the line is active in the next cycle and `cmd_ready` stays 0 for `cfg_setup`+1 cycles.
- R9: After a select release is accepted, the line stays active for `cfg_hold`+1 cycles, then goes inactive, and `cmd_ready` stays 0 for a further `cfg_disable`+1 cycles.
- R10: A select line whose `cfg_cs_pol` bit is 1 is driven 1 when active and 0 when inactive; with the bit 0 the levels are reversed.
- R11: While `rsp_valid`=1 and `rsp_ready`=0 the engine holds `rsp_valid` and `rsp_data` and accepts no command.
- R12: A command with none of `cmd_cs`, `cmd_wr`, `cmd_rd` set is consumed with no effect on the select lines, the serial clock or the response output.
- R13: `cmd_ready` is 0 throughout a byte transfer and every guard time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase: 0 first edge, 1 second edge |
| cfg_div | input | CW | Half-period length minus one, in clock cycles |
| cfg_setup | input | CW | Guard count after select assertion |
| cfg_hold | input | CW | Guard count before select release |
| cfg_disable | input | CW | Guard count after select release |
| cfg_cs_pol | input | NCS | Per-line polarity, 1 = active high |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Engine idle and taking a command |
| cmd_data | input | 8 | Byte to send, or select operation and index |
| cmd_wr | input | 1 | Transmit flag |
| cmd_rd | input | 1 | Capture flag |
| cmd_cs | input | 1 | Select operation flag |
| rsp_valid | output | 1 | Captured byte present |
| rsp_ready | input | 1 | Response sink can take the byte |
| rsp_data | output | 8 | Captured byte |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NCS | Select lines at pin level |

## Verification
The bench builds the block with four select lines and 12-bit counters, and programs small divider and guard values (0 to 5) so each half-period and guard window can be counted cycle by cycle. A polarity mask with one active-high line among active-low ones shows both pin levels, and an index of 100 against four lines reaches the out-of-range select path. A small slave model in the bench, driven by the serial clock, checks both sampling phases under both idle levels.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_RSP,
    ST_SETUP,
    ST_HOLD,
    ST_DIS
  } seq_state_t;

  // Edge numbering within a byte: 0..15, even = first edge of a period.
  function automatic logic is_sample_edge(input logic [3:0] idx, input logic cpha);
    return idx[0] == cpha;
  endfunction

  // Data moves to the next bit on the non-sampling edges; with phase 1 the
  // first bit is already on the line, so edge 0 does not shift.
  function automatic logic is_shift_edge(input logic [3:0] idx, input logic cpha);
    if (cpha) return (idx[0] == 1'b0) && (idx != 4'd0);
    return idx[0] == 1'b1;
  endfunction

  function automatic logic pin_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction

endpackage

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cpol,
  input  logic [CW-1:0] div,
  output logic          sclk,
  output logic          tick,
  output logic [3:0]    edge_idx,
  output logic          last_edge
);

  logic [CW-1:0] cnt;
  logic [3:0]    idx_q;
  logic          sclk_q;

  assign tick      = run && (cnt == div);
  assign last_edge = tick && (idx_q == 4'd15);
  assign edge_idx  = idx_q;
  assign sclk      = run ? sclk_q : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      idx_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      idx_q  <= '0;
      sclk_q <= cpol;
    end else if (tick) begin
      cnt    <= '0;
      idx_q  <= idx_q + 4'd1;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div != '0) && $stable(div)) |=> !tick); // R5

  AST_SCLK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick)) |-> $stable(sclk)); // R5

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter
  import spi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       cpha,
  input  logic       tick,
  input  logic [3:0] edge_idx,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx_byte
);

  logic [7:0] tx_q;
  logic [7:0] rx_q;
  logic       take_bit;
  logic       move_bit;

  assign take_bit = tick && is_sample_edge(edge_idx, cpha);
  assign move_bit = tick && is_shift_edge(edge_idx, cpha);
  assign mosi     = tx_q[7];
  assign rx_byte  = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_byte;
      rx_q <= '0;
    end else begin
      if (take_bit) rx_q <= {rx_q[6:0], miso};
      if (move_bit) tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  AST_ONE_ROLE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_bit && move_bit)); // R6

endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
  import spi_seq_pkg::*;
#(
  parameter int NCS = 4,
  parameter int CW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_cpol,
  input  logic           cfg_cpha,
  input  logic [CW-1:0]  cfg_div,
  input  logic [CW-1:0]  cfg_setup,
  input  logic [CW-1:0]  cfg_hold,
  input  logic [CW-1:0]  cfg_disable,
  input  logic [NCS-1:0] cfg_cs_pol,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [7:0]     cmd_data,
  input  logic           cmd_wr,
  input  logic           cmd_rd,
  input  logic           cmd_cs,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [7:0]     rsp_data,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs
);

  localparam int IDXW = 7;

  function automatic logic [NCS-1:0] line_mask(input logic [IDXW-1:0] idx);
    logic [NCS-1:0] m;
    for (int i = 0; i < NCS; i++) m[i] = (idx == IDXW'(i));
    return m;
  endfunction

  seq_state_t     state;
  logic [CW-1:0]  dly;
  logic [NCS-1:0] cs_act;
  logic [IDXW-1:0] idx_q;
  logic           rd_q;
  logic           wr_q;

  // named internal events
  logic           accept;
  logic           start_xfer;
  logic           cs_op;
  logic           byte_last;
  logic           xfer_run;
  logic           tick;
  logic [3:0]     edge_idx;
  logic [NCS-1:0] sel_now;
  logic [NCS-1:0] sel_held;
  logic           dly_zero;

  assign cmd_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RSP);
  assign accept     = cmd_valid && cmd_ready;
  assign cs_op      = accept && cmd_cs;
  assign start_xfer = accept && !cmd_cs && (cmd_wr || cmd_rd);
  assign xfer_run   = (state == ST_XFER);
  assign sel_now    = line_mask(cmd_data[IDXW-1:0]);
  assign sel_held   = line_mask(idx_q);
  assign dly_zero   = (dly == '0);

  spi_seq_clkgen #(.CW(CW)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (xfer_run),
    .cpol      (cfg_cpol),
    .div       (cfg_div),
    .sclk      (spi_sclk),
    .tick      (tick),
    .edge_idx  (edge_idx),
    .last_edge (byte_last)
  );

  spi_seq_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_xfer),
    .load_byte (cmd_wr ? cmd_data : 8'h00),
    .cpha      (cfg_cpha),
    .tick      (tick),
    .edge_idx  (edge_idx),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_byte   (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dly    <= '0;
      cs_act <= '0;
      idx_q  <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cs_op) begin
            idx_q <= cmd_data[IDXW-1:0];
            if (cmd_data[7]) begin
              cs_act <= cs_act | sel_now;
              dly    <= cfg_setup;
              state  <= ST_SETUP;
            end else begin
              dly   <= cfg_hold;
              state <= ST_HOLD;
            end
          end else if (start_xfer) begin
            rd_q  <= cmd_rd;
            wr_q  <= cmd_wr;
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (byte_last) state <= rd_q ? ST_RSP : ST_IDLE;
        end
        ST_RSP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        ST_SETUP: begin
          if (dly_zero) state <= ST_IDLE;
          else          dly   <= dly - 1'b1;
        end
        ST_HOLD: begin
          if (dly_zero) begin
            cs_act <= cs_act & ~sel_held;
            dly    <= cfg_disable;
            state  <= ST_DIS;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        ST_DIS: begin
          if (dly_zero) state <= ST_IDLE;
          else          dly   <= dly - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_pin
    assign spi_cs[g] = pin_level(cs_act[g], cfg_cs_pol[g]);
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11

  AST_CS_CHANGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act != $past(cs_act)) |-> ($past(state) == ST_IDLE || $past(state) == ST_HOLD)); // R7

  AST_READ_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_run && !wr_q) |-> !spi_mosi); // R3

  AST_NO_TAKE_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R11

  AST_BYTE_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |=> !xfer_run); // R5

endmodule

// File: tb/sim_spi_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_spi_cmd_sequencer;
  localparam int NCS = 4;
  localparam int CW  = 12;
  localparam logic [NCS-1:0] POL = 4'b0010;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic cfg_cpol, cfg_cpha;
  logic [CW-1:0] cfg_div, cfg_setup, cfg_hold, cfg_disable;
  logic [NCS-1:0] cfg_cs_pol;
  logic cmd_valid, cmd_ready, cmd_wr, cmd_rd, cmd_cs;
  logic [7:0] cmd_data;
  logic rsp_valid, rsp_ready;
  logic [7:0] rsp_data;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs;

  spi_cmd_sequencer #(.NCS(NCS), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_disable(cfg_disable), .cfg_cs_pol(cfg_cs_pol),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_cs(cmd_cs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model: counts serial clock transitions, supplies MISO, records MOSI
  logic [7:0] s_tx;
  logic [7:0] m_rx;
  int s_edges;
  logic bcpha;

  always @(spi_sclk) begin
    if (((s_edges % 2) == 1) == bcpha) m_rx = {m_rx[6:0], spi_mosi};
    s_edges = s_edges + 1;
  end

  always_comb begin
    int b;
    b = bcpha ? (s_edges - 1) / 2 : s_edges / 2;
    if (b < 0) b = 0;
    if (b > 7) b = 7;
    spi_miso = s_tx[3'(7 - b)];
  end

  function automatic logic [NCS-1:0] pins(input logic [NCS-1:0] act);
    return ~(act ^ POL);
  endfunction

  task automatic send(input logic c, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_cs = c; cmd_rd = r; cmd_wr = w; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_cs = 1'b0; cmd_rd = 1'b0; cmd_wr = 1'b0;
  endtask

  // vector: cpol, cpha, wr, rd, tx[7:0], slave byte[7:0], div[3:0]
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 4'd0},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h5A, 8'hC3, 4'd1},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h81, 4'd2},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h0F, 4'd0},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h00, 4'd1},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hE7, 4'd0},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'hFE, 4'd3},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h6D, 8'h92, 4'd2}
  };

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    bit seen;
    int n;
    logic prev;
    rst_n = 1'b0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = '0;
    cfg_setup = '0; cfg_hold = '0; cfg_disable = '0; cfg_cs_pol = POL;
    cmd_valid = 1'b0; cmd_wr = 1'b0; cmd_rd = 1'b0; cmd_cs = 1'b0; cmd_data = '0;
    rsp_ready = 1'b1; s_tx = '0; m_rx = '0; s_edges = 0; bcpha = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(cmd_ready), 32'd1);
    chk("R1 cs inactive in reset", 32'(spi_cs), 32'(pins('0)));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 sclk idle after reset", 32'(spi_sclk), 32'(cfg_cpol));

    // table of byte operations, all four modes
    for (int v = 0; v < NV; v++) begin
      logic vpol, vpha, vwr, vrd;
      logic [7:0] vtx, vsb;
      logic [3:0] vdv;
      {vpol, vpha, vwr, vrd, vtx, vsb, vdv} = VEC[v];
      cfg_cpol = vpol; cfg_cpha = vpha; bcpha = vpha; cfg_div = CW'(vdv); s_tx = vsb;
      @(negedge clk);
      s_edges = 0; m_rx = '0;
      send(1'b0, vrd, vwr, vtx);
      chk("R13 not ready during byte", 32'(cmd_ready), 32'd0);
      seen = 0; got = '0;
      while (!cmd_ready) begin
        if (rsp_valid) begin seen = 1; got = rsp_data; end
        @(negedge clk);
      end
      chk("R2 R3 R4 mosi bits", 32'(m_rx), 32'(vwr ? vtx : 8'h00));
      chk("R3 response present", 32'(seen), 32'(vrd));
      if (vrd) chk("R3 R4 captured byte", 32'(got), 32'(vsb));
      chk("R5 transitions per byte", 32'(s_edges), 32'd16);
      chk("R6 sclk rests at cpol", 32'(spi_sclk), 32'(vpol));
    end

    // half-period length
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; bcpha = 1'b0; cfg_div = 12'd3; s_tx = 8'h00;
    send(1'b0, 1'b0, 1'b1, 8'hC9);
    prev = spi_sclk;
    while (spi_sclk == prev) @(negedge clk);
    prev = spi_sclk; n = 0;
    while (spi_sclk == prev) begin n++; @(negedge clk); end
    chk("R5 half period", 32'(n), 32'd4);
    while (!cmd_ready) @(negedge clk);

    // select assertion of an active-high line
    cfg_setup = 12'd5; cfg_hold = 12'd3; cfg_disable = 12'd2;
    send(1'b1, 1'b0, 1'b0, 8'h81);
    chk("R8 R10 line1 asserted high", 32'(spi_cs), 32'(pins(4'b0010)));
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
    chk("R8 setup window", 32'(n), 32'd6);

    // select assertion of an active-low line with zero setup
    cfg_setup = 12'd0;
    send(1'b1, 1'b0, 1'b0, 8'h80);
    chk("R10 line0 asserted low", 32'(spi_cs), 32'(pins(4'b0011)));
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
    chk("R8 zero setup window", 32'(n), 32'd1);

    // release line 1 with hold then disable
    send(1'b1, 1'b0, 1'b0, 8'h01);
    n = 0;
    while (spi_cs[1] == 1'b1) begin n++; @(negedge clk); end
    chk("R9 hold window", 32'(n), 32'd4);
    chk("R9 R10 line1 released", 32'(spi_cs), 32'(pins(4'b0001)));
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
    chk("R9 disable window", 32'(n), 32'd3);

    // out-of-range select index
    cfg_setup = 12'd2;
    send(1'b1, 1'b0, 1'b0, 8'hE4);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
    chk("R7 out of range keeps lines", 32'(spi_cs), 32'(pins(4'b0001)));
    chk("R7 out of range still waits", 32'(n), 32'd3);

    // command with no flags
    prev = spi_sclk;
    send(1'b0, 1'b0, 1'b0, 8'hFF);
    chk("R12 no-op ready again", 32'(cmd_ready), 32'd1);
    chk("R12 no-op lines", 32'(spi_cs), 32'(pins(4'b0001)));
    chk("R12 no-op response", 32'(rsp_valid), 32'd0);
    chk("R12 no-op sclk", 32'(spi_sclk), 32'(prev));

    // response stall
    rsp_ready = 1'b0; cfg_div = 12'd1; s_tx = 8'h96;
    @(negedge clk);
    s_edges = 0; m_rx = '0;
    send(1'b0, 1'b1, 1'b0, 8'h00);
    n = 0;
    while (!rsp_valid && n < 200) begin n++; @(negedge clk); end
    n = 0;
    for (int k = 0; k < 20; k++) begin
      if (rsp_valid && !cmd_ready && rsp_data == 8'h96) n++;
      @(negedge clk);
    end
    chk("R11 held while stalled", 32'(n), 32'd20);
    chk("R11 stalled byte", 32'(rsp_data), 32'h96);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released valid", 32'(rsp_valid), 32'd0);
    chk("R11 released ready", 32'(cmd_ready), 32'd1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule